// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block produces the order of column addresses for one read or write burst of a double-data-rate SDRAM. A controller first loads a mode word. The generator decodes three settings from that word: how many beats a burst has, whether the beats count upward or follow an exclusive-or pattern, and the read latency. The latency is given in half clock cycles, so that the 2.5-cycle setting can be shown exactly. The generator also flags any field code that is reserved. Two further bits of the word, the test-mode bit and the DLL-reset request, are held and exported.

When the controller asserts a burst start, the block captures the starting column and the auto-precharge bit. On the clock cycles that follow, it emits one column address per beat. Column bits above the burst-length boundary keep their start value for the whole burst. The low bits move through the burst-aligned block in the selected order. The last beat is marked, and a start accepted on that beat runs the next burst with no idle cycle.

Top module: `ddr_burst_colgen`

## Requirements
- R1: Mode word bits [2:0] set the burst length: 3'b001 gives 2 beats, 3'b010 gives 4 and 3'b011 gives 8. `cfgBurstLen` shows that count. Every other code drives `cfgBurstLen` to 0 and raises `badBurstLen`.
- R2: Mode word bits [6:4] set the read latency in half cycles on `cfgCasHalf`: 3'b011 gives 6 (3 cycles) and 3'b110 gives 5 (2.5 cycles). Every other code gives 0 and raises `badCasLat`.
- R3: Mode word bit 3 selects the ordering on `cfgInterleave`: 0 means sequential and 1 means interleaved.
- R4: Mode word bit 7 is shown on `cfgTestMode` and bit 8 on `cfgDllReset`. The mode word is captured on a clock edge where `modeLoad` is high, and the decoded outputs follow in the next cycle.
- R5: `modeErr` is high whenever either field code is reserved. While it is high, a burst start is ignored and no beat is issued.
- R6: After a start is accepted at a clock edge, `beatValid` is high for exactly as many consecutive cycles as the burst has beats, beginning in the next cycle.
- R7: In sequential order, beat k carries (start + k) modulo the burst length in the low bits. For example, start 5 with 8 beats gives 5,6,7,0,1,2,3,4.
- R8: In interleaved order, beat k carries the start's low bits XOR k. For example, start 5 with 8 beats gives 5,4,7,6,1,0,3,2.
- R9: The 10-bit column's bits above the burst-length boundary equal the start value on every beat. `beatAp` repeats the `startAp` captured at the start on every beat.
- R10: `beatLast` is high on the final beat of each burst. A start accepted in that cycle makes the next burst's first beat appear in the following cycle.
- R11: A start raised during a burst before its final beat is ignored. A mode load during a burst does not change the length or ordering of the burst in progress.
- R12: After reset no beat is issued, the mode word is all zero, and `modeErr` is therefore high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeLoad | input | 1 | Capture `modeWord` at this edge |
| modeWord | input | 13 | Mode word |
| burstStart | input | 1 | Request a new burst |
| startCol | input | 10 | Starting column of the burst |
| startAp | input | 1 | Auto-precharge mark for the burst |
| beatValid | output | 1 | A beat address is present |
| beatCol | output | 10 | Column address of the current beat |
| beatAp | output | 1 | Auto-precharge mark of the current burst |
| beatLast | output | 1 | Current beat is the burst's last |
| cfgBurstLen | output | 4 | Decoded beat count (0 when reserved) |
| cfgInterleave | output | 1 | Interleaved ordering selected |
| cfgCasHalf | output | 3 | Read latency in half cycles (0 when reserved) |
| cfgTestMode | output | 1 | Test-mode bit of the mode word |
| cfgDllReset | output | 1 | DLL-reset request bit of the mode word |
| badBurstLen | output | 1 | Burst-length code is reserved |
| badCasLat | output | 1 | Latency code is reserved |
| modeErr | output | 1 | Either code is reserved |

## Verification
Bursts of 2, 4 and 8 beats are run in both orderings. The start columns have nonzero upper bits and low bits at every alignment. An unaligned start separates the upward wrap from the XOR pattern, and the upper bits show whether the wrap stays inside its block. Starts are also placed on the final beat, in the middle of a burst, and under a reserved mode code. Mode reloads are made during a burst. Together these show back-to-back chaining, rejection of a start, and that the burst in progress keeps its own settings. Every reserved code of both fields is loaded, along with both valid latency codes and the two status bits.

// File: rtl/colgen_pkg.sv
package colgen_pkg;
  // Widest burst is 8 beats, so the beat index needs 3 bits.
  localparam int IX_W = 3;

  typedef struct packed {
    logic            capture;  // latch start column and precharge mark
    logic            ilv;      // interleaved ordering for this burst
    logic [IX_W-1:0] idx;      // current beat index
    logic [IX_W-1:0] mask;     // low-bit mask of the burst block
  } dp_ctl_t;
endpackage

// File: rtl/colgen_ctrl.sv
module colgen_ctrl
  import colgen_pkg::*;
#(
  parameter int MODE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              burstStart,
  output logic              beatValid,
  output logic              beatLast,
  output logic [3:0]        cfgBurstLen,
  output logic              cfgInterleave,
  output logic [2:0]        cfgCasHalf,
  output logic              cfgTestMode,
  output logic              cfgDllReset,
  output logic              badBurstLen,
  output logic              badCasLat,
  output logic              modeErr,
  output dp_ctl_t           dpCtl
);
  logic [MODE_W-1:0] modeQ;
  logic [IX_W-1:0]   maskNow;
  logic              busyQ;
  logic [IX_W-1:0]   idxQ;
  logic [IX_W-1:0]   maskQ;
  logic              ilvQ;
  logic              lastNow;
  logic              accept;

  always_ff @(posedge clk) begin
    if (!rstN)         modeQ <= '0;
    else if (modeLoad) modeQ <= modeWord;
  end

  // Field decode of the stored mode word.
  always_comb begin
    badBurstLen = 1'b0;
    maskNow     = '0;
    cfgBurstLen = 4'd0;
    unique case (modeQ[2:0])
      3'b001:  begin maskNow = 3'd1; cfgBurstLen = 4'd2; end
      3'b010:  begin maskNow = 3'd3; cfgBurstLen = 4'd4; end
      3'b011:  begin maskNow = 3'd7; cfgBurstLen = 4'd8; end
      default: badBurstLen = 1'b1;
    endcase
  end

  always_comb begin
    badCasLat  = 1'b0;
    cfgCasHalf = 3'd0;
    unique case (modeQ[6:4])
      3'b011:  cfgCasHalf = 3'd6;
      3'b110:  cfgCasHalf = 3'd5;
      default: badCasLat = 1'b1;
    endcase
  end

  assign cfgInterleave = modeQ[3];
  assign cfgTestMode   = modeQ[7];
  assign cfgDllReset   = modeQ[8];
  assign modeErr       = badBurstLen | badCasLat;

  assign lastNow = busyQ && (idxQ == maskQ);
  assign accept  = burstStart && !modeErr && (!busyQ || lastNow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
      maskQ <= '0;
      ilvQ  <= 1'b0;
    end else if (accept) begin
      busyQ <= 1'b1;
      idxQ  <= '0;
      maskQ <= maskNow;
      ilvQ  <= modeQ[3];
    end else if (lastNow) begin
      busyQ <= 1'b0;
      idxQ  <= '0;
    end else if (busyQ) begin
      idxQ  <= idxQ + 1'b1;
    end
  end

  assign beatValid     = busyQ;
  assign beatLast      = lastNow;
  assign dpCtl.capture = accept;
  assign dpCtl.ilv     = ilvQ;
  assign dpCtl.idx     = idxQ;
  assign dpCtl.mask    = maskQ;
endmodule

// File: rtl/colgen_dp.sv
module colgen_dp
  import colgen_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctl_t          dpCtl,
  input  logic [COL_W-1:0] startCol,
  input  logic             startAp,
  output logic [COL_W-1:0] beatCol,
  output logic             beatAp
);
  logic [COL_W-1:0] startQ;
  logic             apQ;
  logic [IX_W-1:0]  lowMix;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      apQ    <= 1'b0;
    end else if (dpCtl.capture) begin
      startQ <= startCol;
      apQ    <= startAp;
    end
  end

  assign lowMix = dpCtl.ilv ? (startQ[IX_W-1:0] ^ dpCtl.idx)
                            : (startQ[IX_W-1:0] + dpCtl.idx);

  for (genvar gi = 0; gi < COL_W; gi++) begin : g_bit
    if (gi < IX_W) begin : g_low
      assign beatCol[gi] = dpCtl.mask[gi] ? lowMix[gi] : startQ[gi];
    end else begin : g_high
      assign beatCol[gi] = startQ[gi];
    end
  end

  assign beatAp = apQ;
endmodule

// File: rtl/ddr_burst_colgen.sv
module ddr_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int MODE_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              burstStart,
  input  logic [COL_W-1:0]  startCol,
  input  logic              startAp,
  output logic              beatValid,
  output logic [COL_W-1:0]  beatCol,
  output logic              beatAp,
  output logic              beatLast,
  output logic [3:0]        cfgBurstLen,
  output logic              cfgInterleave,
  output logic [2:0]        cfgCasHalf,
  output logic              cfgTestMode,
  output logic              cfgDllReset,
  output logic              badBurstLen,
  output logic              badCasLat,
  output logic              modeErr
);
  dp_ctl_t dpCtl;

  colgen_ctrl #(.MODE_W(MODE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeWord(modeWord),
    .burstStart(burstStart), .beatValid(beatValid), .beatLast(beatLast),
    .cfgBurstLen(cfgBurstLen), .cfgInterleave(cfgInterleave),
    .cfgCasHalf(cfgCasHalf), .cfgTestMode(cfgTestMode),
    .cfgDllReset(cfgDllReset), .badBurstLen(badBurstLen),
    .badCasLat(badCasLat), .modeErr(modeErr), .dpCtl(dpCtl)
  );

  colgen_dp #(.COL_W(COL_W)) i_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .startCol(startCol),
    .startAp(startAp), .beatCol(beatCol), .beatAp(beatAp)
  );
endmodule

// File: rtl/colgen_checker.sv
module colgen_checker #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             beatValid,
  input logic             beatLast,
  input logic [COL_W-1:0] beatCol,
  input logic             beatAp,
  input logic             modeErr,
  input logic             badBurstLen,
  input logic [3:0]       cfgBurstLen
);
  p_last_in_burst_r10: assert property (@(posedge clk) disable iff (!rstN)
    beatLast |-> beatValid);

  p_burst_continues_r6: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatLast) |=> beatValid);

  p_high_bits_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !beatLast) |=> ($stable(beatCol[COL_W-1:3]) && $stable(beatAp)));

  p_no_start_on_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!beatValid && modeErr) |=> !beatValid);

  p_len_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    !badBurstLen |-> ($countones(cfgBurstLen) == 1));
endmodule

bind ddr_burst_colgen colgen_checker #(.COL_W(COL_W)) i_chk (
  .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatLast(beatLast),
  .beatCol(beatCol), .beatAp(beatAp), .modeErr(modeErr),
  .badBurstLen(badBurstLen), .cfgBurstLen(cfgBurstLen)
);

// File: tb/test_ddr_burst_colgen.sv
module test_ddr_burst_colgen;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeLoad = 1'b0;
  logic [12:0] modeWord = '0;
  logic        burstStart = 1'b0;
  logic [9:0]  startCol = '0;
  logic        startAp = 1'b0;
  logic        beatValid, beatAp, beatLast;
  logic [9:0]  beatCol;
  logic [3:0]  cfgBurstLen;
  logic        cfgInterleave, cfgTestMode, cfgDllReset;
  logic [2:0]  cfgCasHalf;
  logic        badBurstLen, badCasLat, modeErr;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ddr_burst_colgen i_ddr_burst_colgen (.*);

  // Reference model state
  logic [12:0] mMode = '0;
  int qCol[$];
  int qAp[$];
  int qLast[$];
  int qIlv[$];

  function automatic int lenOf(logic [12:0] w);
    case (w[2:0])
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int casOf(logic [12:0] w);
    case (w[6:4])
      3'b011: return 6;
      3'b110: return 5;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = '0;
      qCol.delete(); qAp.delete(); qLast.delete(); qIlv.delete();
    end else begin
      int len;
      bit err, acc;
      len = lenOf(mMode);
      err = (len == 0) || (casOf(mMode) == 0);
      acc = burstStart && !err && (qCol.size() <= 1);
      if (qCol.size() > 0) begin
        void'(qCol.pop_front()); void'(qAp.pop_front());
        void'(qLast.pop_front()); void'(qIlv.pop_front());
      end
      if (acc) begin
        for (int k = 0; k < len; k++) begin
          int lo;
          if (mMode[3]) lo = (startCol % len) ^ k;
          else          lo = ((startCol % len) + k) % len;
          qCol.push_back((startCol / len) * len + lo);
          qAp.push_back(startAp);
          qLast.push_back(k == len - 1);
          qIlv.push_back(mMode[3]);
        end
      end
      if (modeLoad) mMode = modeWord;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      int el, ec;
      el = lenOf(mMode);
      ec = casOf(mMode);
      check(cfgBurstLen == el, "R1 len", cfgBurstLen, el);
      check(badBurstLen == (el == 0), "R1 bad", badBurstLen, el == 0);
      check(cfgCasHalf == ec, "R2 cas", cfgCasHalf, ec);
      check(badCasLat == (ec == 0), "R2 bad", badCasLat, ec == 0);
      check(cfgInterleave == mMode[3], "R3 type", cfgInterleave, mMode[3]);
      check(cfgTestMode == mMode[7], "R4 test", cfgTestMode, mMode[7]);
      check(cfgDllReset == mMode[8], "R4 dll", cfgDllReset, mMode[8]);
      check(modeErr == (el == 0 || ec == 0), "R5 err", modeErr, el == 0 || ec == 0);
      check(beatValid == (qCol.size() > 0), "R6/R11 valid", beatValid, qCol.size() > 0);
      if (qCol.size() > 0 && beatValid) begin
        // R7 sequential, R8 interleaved order
        check(beatCol[2:0] == qCol[0][2:0], qIlv[0] ? "R8 order" : "R7 order",
              beatCol, qCol[0]);
        check(beatCol[9:3] == qCol[0][9:3], "R9 high", beatCol, qCol[0]);
        check(beatAp == qAp[0], "R9 ap", beatAp, qAp[0]);
        check(beatLast == qLast[0], "R10 last", beatLast, qLast[0]);
      end
    end
  end

  task automatic loadMode(logic [12:0] w);
    @(negedge clk); modeLoad = 1'b1; modeWord = w;
    @(negedge clk); modeLoad = 1'b0;
  endtask

  task automatic startAt(logic [9:0] c, logic ap);
    @(negedge clk); burstStart = 1'b1; startCol = c; startAp = ap;
    @(negedge clk); burstStart = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Explicit check of the stated 8-beat example sequences
  task automatic expectSeq(logic [12:0] w, int exp[8], string req);
    loadMode(w);
    @(negedge clk); burstStart = 1'b1; startCol = 10'd5; startAp = 1'b0;
    @(negedge clk); burstStart = 1'b0;
    for (int k = 0; k < 8; k++) begin
      check(beatValid && beatCol == exp[k], req, beatCol, exp[k]);
      @(negedge clk);
    end
    check(!beatValid, "R6 end", beatValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(!beatValid, "R12 no beat", beatValid, 0);
    check(modeErr, "R12 err", modeErr, 1);
    rstN = 1'b1;
    startAt(10'h155, 1'b1);                 // R5 ignored under reset mode
    idle(3);
    expectSeq(13'h033, '{5,6,7,0,1,2,3,4}, "R7 example");
    expectSeq(13'h03B, '{5,4,7,6,1,0,3,2}, "R8 example");
    // Each length and ordering with assorted starts
    for (int t = 0; t < 6; t++) begin
      logic [12:0] w;
      w = {4'b0, 1'b0, 1'b0, (t % 2 == 0) ? 3'b011 : 3'b110,
           t[0] ^ t[1], 1'b0, 2'(t / 2 + 1)};
      loadMode(w);
      for (int s = 0; s < 8; s++) begin
        startAt(10'(s * 73 + 640), s[0]);
        idle(8);
      end
    end
    // R10 back-to-back: start on last beat of a 4-beat burst
    loadMode(13'h032);
    startAt(10'h1F6, 1'b1);
    idle(2);
    @(negedge clk); burstStart = 1'b1; startCol = 10'h20B; startAp = 1'b0;
    @(negedge clk); burstStart = 1'b0;
    idle(6);
    // R11 start in mid-burst ignored; mode load mid-burst
    loadMode(13'h03B);
    startAt(10'h0A2, 1'b0);
    @(negedge clk); burstStart = 1'b1; startCol = 10'h3FF;
    modeLoad = 1'b1; modeWord = 13'h031;
    @(negedge clk); burstStart = 1'b0; modeLoad = 1'b0;
    idle(10);
    // R1 and R2 reserved codes, R5 start blocked
    for (int c = 0; c < 8; c++) begin
      loadMode({4'b0, 1'b0, 1'b0, 3'b011, 1'b0, 3'(c)});
      startAt(10'(c * 37), 1'b1);
      idle(9);
      loadMode({4'b0, 1'b0, 1'b0, 3'(c), 1'b1, 3'b010});
      startAt(10'(c * 91), 1'b0);
      idle(5);
    end
    // R4 status bits
    loadMode(13'h1B3);
    idle(2);
    loadMode(13'h0E3);
    idle(2);
    loadMode(13'h163);
    startAt(10'h3FD, 1'b1);
    idle(4);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule